// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns 16-bit stereo sample pairs into a three-wire serial audio stream: a bit clock, a word clock that marks the channel, and a data line. It derives the bit clock from a master clock enable: each enable pulse is one half period of the bit clock. The frame is the stereo sample period. Its length in bit clocks and its layout are selectable.

Two layouts exist. The first is I2S style, with the word clock low for the left channel and the most significant bit one bit clock after the word clock changes. It runs at 48 or 64 bit clocks per frame. The second is right-justified, with the word clock high for the left channel and the least significant bit in the last slot of each half frame. It runs at 32, 48 or 64 bit clocks per frame. Both send data most significant bit first. The block pulses a request when a frame begins, and it latches the input pair in that cycle. The upstream source answers the pulse by presenting the next pair. Format and ratio inputs are sampled only when a frame starts.

Top module: `audio_serial_tx`

## Requirements
- R1: `bclk` is low after reset and toggles in the cycle after each clock where `mclk_en` is high. It holds otherwise.
- R2: `wclk` and `sdata` change only in the cycle in which `bclk` falls.
- R3: `sample_req` is high for exactly one cycle, in the cycle `bclk` falls to begin a frame. The first fall after reset begins a frame. `in_left`/`in_right` are captured in that same clock.
- R4: A frame lasts 32 bit clocks for `ratio_sel`=00 (right-justified only), 48 for 01, and 64 for 10 or 11. Bit clocks are counted as falls of `bclk`.
- R5: With `fmt_sel`=0 (I2S), `wclk` is low in the first half frame (left) and high in the second (right). Slot 0 of each half is padding. Slots 1 to 16 carry the word, most significant bit first.
- R6: With `fmt_sel`=0 and `ratio_sel`=00, the frame is 64 bit clocks.
- R7: With `fmt_sel`=1 (right-justified), `wclk` is high in the left half and low in the right half. The 16 word bits, most significant bit first, fill the last 16 slots of each half, so bit 0 occupies the final slot.
- R8: Every slot not carrying a word bit drives `sdata` low.
- R9: A change of `fmt_sel` or `ratio_sel` has no effect on `wclk`, `sdata` or the frame length until the next frame begins.
- R10: While `rst_n` is low, `bclk`, `wclk`, `sdata` and `sample_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_en | input | 1 | Half-bit-period strobe from the master clock |
| fmt_sel | input | 1 | 0: I2S style, 1: right-justified |
| ratio_sel | input | 2 | 00: 32, 01: 48, 1x: 64 bit clocks per frame |
| in_left | input | 16 | Left channel sample |
| in_right | input | 16 | Right channel sample |
| bclk | output | 1 | Serial bit clock |
| wclk | output | 1 | Word (channel) clock |
| sdata | output | 1 | Serial data, changes on falling `bclk` |
| sample_req | output | 1 | One-cycle pulse when a new pair is taken |

## Verification
The frame start and the first slot of the new frame fall in the same cycle. In that cycle the block latches a new pair, adopts a new format and ratio, and drives slot 0. In right-justified 32-clock frames, that slot already carries the new left word's top bit. The bench provokes this collision by changing the format, the ratio and the samples at arbitrary cycles, including the cycle just before a boundary. Its model adopts the configuration only at the frame start and predicts slot 0 from the pair just presented. A mismatch in slot 0 or in the frame length shows whether the design used the stale or the new values.

// File: rtl/aso_pkg.sv
package aso_pkg;
  localparam int SAMPLE_W  = 16;
  localparam int MAX_FRAME = 64;
  localparam int SLOT_W    = $clog2(MAX_FRAME) + 1;
  localparam int IDX_W     = $clog2(SAMPLE_W);

  typedef enum logic {FMT_I2S = 1'b0, FMT_RJ = 1'b1} fmt_e;

  typedef struct packed {
    fmt_e              fmt;
    logic [SLOT_W-1:0] len;
  } cfg_t;

  // bit clocks per frame; I2S has no 32-clock frame and runs at 64 instead
  function automatic logic [SLOT_W-1:0] frame_len(fmt_e fmt, logic [1:0] ratio);
    case (ratio)
      2'b00:   return (fmt == FMT_RJ) ? SLOT_W'(32) : SLOT_W'(64);
      2'b01:   return SLOT_W'(48);
      default: return SLOT_W'(64);
    endcase
  endfunction

  // word bit carried by a slot, or -1 for a padding slot
  function automatic int word_index(fmt_e fmt, int half, int pos);
    if (fmt == FMT_RJ) begin
      if (pos + SAMPLE_W >= half) return half - 1 - pos;
      return -1;
    end
    if (pos >= 1 && pos <= SAMPLE_W) return SAMPLE_W - pos;
    return -1;
  endfunction
endpackage

// File: rtl/aso_bclk_gen.sv
module aso_bclk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  output logic bclk,
  output logic fall
);
  logic bclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bclk_q <= 1'b0;
    else if (tick_en) bclk_q <= ~bclk_q;
  end

  assign bclk = bclk_q;
  assign fall = tick_en & bclk_q;

  p_bclk_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(bclk_q));
endmodule

// File: rtl/aso_slot_ctr.sv
module aso_slot_ctr
  import aso_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              fmt_in,
  input  logic [1:0]        ratio_in,
  output logic              frame_start,
  output logic [SLOT_W-1:0] nxt_slot,
  output cfg_t              nxt_cfg
);
  logic [SLOT_W-1:0] slot_q;
  cfg_t              cfg_q;
  logic              fresh_q;
  logic              at_last;

  assign at_last     = (slot_q == cfg_q.len - SLOT_W'(1));
  assign frame_start = fall & (fresh_q | at_last);

  always_comb begin
    nxt_cfg  = cfg_q;
    nxt_slot = slot_q;
    if (frame_start) begin
      nxt_cfg.fmt = fmt_e'(fmt_in);
      nxt_cfg.len = frame_len(fmt_e'(fmt_in), ratio_in);
      nxt_slot    = '0;
    end else if (fall) begin
      nxt_slot = slot_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      cfg_q   <= '{fmt: FMT_I2S, len: SLOT_W'(MAX_FRAME)};
      fresh_q <= 1'b1;
    end else begin
      slot_q <= nxt_slot;
      cfg_q  <= nxt_cfg;
      if (fall) fresh_q <= 1'b0;
    end
  end

  p_slot_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < cfg_q.len);
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cfg_q));
endmodule

// File: rtl/aso_slot_map.sv
module aso_slot_map
  import aso_pkg::*;
(
  input  cfg_t                cfg,
  input  logic [SLOT_W-1:0]   slot,
  input  logic [SAMPLE_W-1:0] left,
  input  logic [SAMPLE_W-1:0] right,
  output logic                wclk_lvl,
  output logic                data_bit,
  output logic                pad_slot
);
  int                  half;
  int                  pos;
  int                  idx;
  logic                is_right;
  logic [SAMPLE_W-1:0] word;
  logic [IDX_W-1:0]    sel;

  always_comb begin
    half     = int'(cfg.len) / 2;
    is_right = int'(slot) >= half;
    pos      = is_right ? int'(slot) - half : int'(slot);
    word     = is_right ? right : left;
    idx      = word_index(cfg.fmt, half, pos);
    pad_slot = (idx < 0);
    sel      = pad_slot ? '0 : IDX_W'(idx);
    data_bit = pad_slot ? 1'b0 : word[sel];
    wclk_lvl = (cfg.fmt == FMT_RJ) ? ~is_right : is_right;
  end
endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import aso_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mclk_en,
  input  logic                fmt_sel,
  input  logic [1:0]          ratio_sel,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                bclk,
  output logic                wclk,
  output logic                sdata,
  output logic                sample_req
);
  logic                fall;
  logic                frame_start;
  logic [SLOT_W-1:0]   nxt_slot;
  cfg_t                nxt_cfg;
  logic [SAMPLE_W-1:0] hold_l, hold_r;
  logic [SAMPLE_W-1:0] use_l, use_r;
  logic                wclk_lvl, data_bit, pad_slot;
  logic                wclk_q, sdata_q, req_q;
  fmt_e                fmt_q;

  aso_bclk_gen u_bclk (
    .clk(clk), .rst_n(rst_n), .tick_en(mclk_en), .bclk(bclk), .fall(fall)
  );

  aso_slot_ctr u_slot (
    .clk(clk), .rst_n(rst_n), .fall(fall), .fmt_in(fmt_sel),
    .ratio_in(ratio_sel), .frame_start(frame_start),
    .nxt_slot(nxt_slot), .nxt_cfg(nxt_cfg)
  );

  // the first slot of a frame is built from the pair being latched now
  assign use_l = frame_start ? in_left  : hold_l;
  assign use_r = frame_start ? in_right : hold_r;

  aso_slot_map u_map (
    .cfg(nxt_cfg), .slot(nxt_slot), .left(use_l), .right(use_r),
    .wclk_lvl(wclk_lvl), .data_bit(data_bit), .pad_slot(pad_slot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l  <= '0;
      hold_r  <= '0;
      wclk_q  <= 1'b0;
      sdata_q <= 1'b0;
      req_q   <= 1'b0;
      fmt_q   <= FMT_I2S;
    end else begin
      req_q <= frame_start;
      if (frame_start) begin
        hold_l <= in_left;
        hold_r <= in_right;
        fmt_q  <= nxt_cfg.fmt;
      end
      if (fall) begin
        wclk_q  <= wclk_lvl;
        sdata_q <= data_bit;
      end
    end
  end

  assign wclk       = wclk_q;
  assign sdata      = sdata_q;
  assign sample_req = req_q;

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(bclk) |-> ($stable(wclk) && $stable(sdata)));
  p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req |=> !sample_req);
  p_req_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req |-> $fell(bclk));
  p_start_wclk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req |-> (wclk == (fmt_q == FMT_RJ)));
  p_pad_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && pad_slot) |=> !sdata);
endmodule

// File: tb/audio_serial_tx_test.sv
`timescale 1ns/1ps
module audio_serial_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mclk_en = 1'b0;
  logic        fmt_sel = 1'b0;
  logic [1:0]  ratio_sel = 2'b00;
  logic [15:0] in_left = 16'h0;
  logic [15:0] in_right = 16'h0;
  wire         bclk, wclk, sdata, sample_req;

  audio_serial_tx uut (
    .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .fmt_sel(fmt_sel),
    .ratio_sel(ratio_sel), .in_left(in_left), .in_right(in_right),
    .bclk(bclk), .wclk(wclk), .sdata(sdata), .sample_req(sample_req)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit started = 1'b0;
  int cnt = 0;
  int cur_len = 64;
  bit cur_rj = 1'b0;
  logic [1:0] cur_ratio = 2'b00;
  logic [15:0] cur_l = 16'h0, cur_r = 16'h0;
  logic pb = 1'b0, pw = 1'b0, ps = 1'b0;
  bit en_prev = 1'b0;
  int en_mode = 0;
  bit cfg_rand = 1'b0;
  int frames = 0;
  int pair_no = 0;

  function automatic logic [15:0] adv(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic int blen(bit rj, logic [1:0] r);
    if (r == 2'b01) return 48;
    if (r == 2'b00 && rj) return 32;
    return 64;
  endfunction

  // expected line level: place the half-frame word in a 64-bit window
  function automatic bit ebit(bit rj, int len, int slot, logic [15:0] l, logic [15:0] r);
    int half = len / 2;
    int pos = (slot < half) ? slot : slot - half;
    logic [15:0] w = (slot < half) ? l : r;
    logic [63:0] v;
    if (rj) v = {48'h0, w} << (64 - half);
    else    v = {1'b0, w, 47'h0};
    return v[63 - pos];
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    bit fall, bexp, ew, eb, pad;
    int slot, half, pos;
    string t;
    @(negedge clk);
    if (!rst_n) begin
      check(!bclk && !wclk && !sdata && !sample_req, "R10 reset outputs",
            {bclk, wclk, sdata, sample_req}, 0);
    end else begin
      check((bclk != pb) == en_prev, "R1 bclk toggles on enable", bclk, en_prev ? !pb : pb);
      fall = pb && !bclk;
      if (fall) begin
        bexp = !started || cnt == cur_len;
        t = "R3 R4 frame boundary";
        if (started && !cur_rj && cur_ratio == 2'b00) t = "R3 R6 frame boundary";
        check(sample_req == bexp, t, sample_req, bexp);
        if (bexp) begin
          started = 1'b1; cnt = 0; frames++;
          cur_rj = fmt_sel; cur_ratio = ratio_sel; cur_len = blen(fmt_sel, ratio_sel);
          cur_l = in_left; cur_r = in_right;
        end
        slot = cnt; cnt++;
        half = cur_len / 2;
        pos = (slot < half) ? slot : slot - half;
        ew = cur_rj ? (slot < half) : (slot >= half);
        t = cur_rj ? "R7 word clock" : "R5 word clock";
        if (!bexp && (fmt_sel != cur_rj || blen(fmt_sel, ratio_sel) != cur_len))
          t = {t, " R9"};
        check(wclk == ew, t, wclk, ew);
        eb = ebit(cur_rj, cur_len, slot, cur_l, cur_r);
        pad = cur_rj ? (pos < half - 16) : (pos == 0 || pos > 16);
        t = pad ? "R8 padding" : (cur_rj ? "R7 data" : "R5 data");
        check(sdata == eb, t, sdata, eb);
      end else begin
        check(!sample_req, "R3 request only at a fall", sample_req, 0);
        check(wclk == pw && sdata == ps, "R2 outputs hold between falls",
              {wclk, sdata}, {pw, ps});
      end
    end
    pb = bclk; pw = wclk; ps = sdata;
    lfsr = adv(lfsr);
    if (rst_n && sample_req) begin
      pair_no++;
      case (pair_no % 4)
        0: begin in_left = 16'h8000; in_right = 16'h0001; end
        1: begin in_left = 16'hFFFF; in_right = 16'h0000; end
        2: begin in_left = 16'h0001; in_right = 16'h8000; end
        default: begin in_left = lfsr; in_right = adv(lfsr) ^ 16'h5A5A; end
      endcase
    end
    if (cfg_rand && lfsr[4:0] == 5'd0) begin
      fmt_sel = lfsr[7];
      ratio_sel = lfsr[9:8];
    end
    case (en_mode)
      0: mclk_en = rst_n;
      1: mclk_en = rst_n && lfsr[1:0] == 2'b00;
      default: mclk_en = rst_n && lfsr[2];
    endcase
    en_prev = mclk_en;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    in_left = 16'h8000; in_right = 16'h0001;
    repeat (4) step();
    rst_n = 1'b1;
    for (int f = 0; f < 2; f++) begin
      for (int r = 0; r < 4; r++) begin
        for (int m = 0; m < 3; m++) begin
          fmt_sel = f[0]; ratio_sel = r[1:0]; en_mode = m;
          frames = 0;
          while (frames < 3) step();
        end
      end
    end
    cfg_rand = 1'b1;
    for (int m = 0; m < 3; m++) begin
      en_mode = m;
      repeat (6000) step();
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule